// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control state machine in a small CPU core that takes a pending interrupt and carries out the fixed entry steps before the handler's first instruction runs. A hardware request is examined when the running instruction completes. It is also examined at once while a suspendable long instruction is in flight, such as a string move, a string store or a repeat multiply-accumulate. When that happens the block aborts the instruction. A software-interrupt (trap) instruction enters the same sequence when it completes.

After acceptance the sequencer goes through seven further cycles in a fixed order. It reads the interrupt information at address zero and clears the request. It then writes the cleared flags and pushes the flag snapshot and the program counter onto the stack, using the stack pointer chosen by the updated select flag. Finally it loads the new priority level and redirects fetch to the handler. A latency counter reports the length of the sequence, so the total response time can be measured.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, busy, instr_abort, info_rd, req_clr, flags_we, stk_we, sp_we, ipl_we and redirect are all 0 and lat_count is 0.
- R2: In an idle cycle (cycle A), busy rises and the sequence starts when either of two conditions holds. The first is swi_req=1 with instr_done=1, which is accepted unconditionally. The second is req_pending=1 with interrupt-enable flag bit 6 of flags_in set, req_level greater than ipl_cur, and an instruction boundary. If both conditions hold, the software entry wins.
- R3: An instruction boundary is instr_done=1, or instr_susp=1 for a suspendable instruction. A hardware entry taken with instr_susp=1 and instr_done=0 pulses instr_abort in cycle A. With neither input high, no hardware request is accepted.
- R4: In cycle A+1, info_rd is 1 for a hardware entry and 0 for a software entry, and info_addr is 0. A hardware entry takes its vector number and level from info_vec and info_lvl in that cycle.
- R5: In cycle A+2, req_clr pulses for a hardware entry only.
- R6: In cycle A+3, flags_we is 1 and flags_out equals the flags_in value sampled in cycle A with bit 6 (interrupt enable) and bit 5 (debug) cleared. Bit 7 (stack select) is also cleared, unless the entry is a software interrupt numbered 32 to 63, in which case bit 7 keeps its value.
- R7: In cycle A+4, stk_we is 1, stk_wdata is the cycle-A flag snapshot, and stk_addr is SP-2. SP is usp_in when the new bit 7 is 1 and isp_in when it is 0.
- R8: In cycle A+5, stk_we is 1, stk_wdata is the pc_in of cycle A, and stk_addr is SP-4. sp_we is 1, sp_new is SP-4, and sp_sel equals the new bit 7.
- R9: In cycle A+6, ipl_we is 1 with ipl_out equal to the captured level for a hardware entry. For a software entry, ipl_we stays 0.
- R10: In cycle A+7, redirect is 1 and redirect_addr is 0xFF00 + 4*vector. The vector is the captured info_vec for a hardware entry and swi_num for a software entry.
- R11: busy stays 1 from cycle A through A+7, and no request is accepted during that time. In cycle A+8 the block is idle again.
- R12: lat_count is 7 in the redirect cycle and holds that value until the next acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_done | input | 1 | Current instruction completes this cycle |
| instr_susp | input | 1 | Current instruction is a suspendable long instruction |
| req_pending | input | 1 | Hardware interrupt request pending |
| req_level | input | 3 | Level of the pending hardware request |
| swi_req | input | 1 | Current instruction is a software-interrupt trap |
| swi_num | input | 6 | Software-interrupt number |
| flags_in | input | 16 | Current flag register |
| pc_in | input | 16 | Program counter to save |
| ipl_cur | input | 3 | Current interrupt priority level |
| isp_in | input | 16 | Interrupt stack pointer |
| usp_in | input | 16 | User stack pointer |
| info_vec | input | 6 | Vector number read from the information address |
| info_lvl | input | 3 | Level read from the information address |
| busy | output | 1 | Entry sequence active |
| instr_abort | output | 1 | Suspend the running long instruction |
| info_rd | output | 1 | Interrupt information read strobe |
| info_addr | output | 16 | Information read address (always 0) |
| req_clr | output | 1 | Clear the accepted request bit |
| flags_we | output | 1 | Flag register write strobe |
| flags_out | output | 16 | New flag register value |
| stk_we | output | 1 | Stack write request |
| stk_addr | output | 16 | Stack write address |
| stk_wdata | output | 16 | Stack write data |
| sp_we | output | 1 | Stack pointer update strobe |
| sp_sel | output | 1 | Which stack pointer is updated (1 = user) |
| sp_new | output | 16 | Updated stack pointer value |
| ipl_we | output | 1 | Priority level write strobe |
| ipl_out | output | 3 | New priority level |
| redirect | output | 1 | Redirect fetch to the handler |
| redirect_addr | output | 16 | Handler address |
| lat_count | output | 4 | Cycles from acceptance to redirect |

## Verification
Acceptance and abort are combinational and are checked in cycle A itself, one time unit after the stimulus is applied at the falling edge. Each later result has a fixed due cycle: the information read at A+1, the request clear at A+2, the flag write at A+3, the two pushes at A+4 and A+5, the level write at A+6 and the redirect at A+7. The bench steps one rising edge at a time and samples each output at the falling edge of its due cycle. After cycle A it scrambles the flag, program counter and information inputs, so that only values captured in the correct cycle can match. During the sequence it keeps strong requests asserted to test the busy lockout, then checks for idle at A+8.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int FLG_W  = 16;
    localparam int VEC_W  = 6;
    localparam int LVL_W  = 3;
    localparam int LAT_W  = 4;

    localparam int FLG_DBG = 5;
    localparam int FLG_IEN = 6;
    localparam int FLG_SSEL = 7;

    localparam int SWI_KEEP_MIN = 32;
    localparam int ENTRY_LAT    = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INFO,
        ST_CLRQ,
        ST_FLAG,
        ST_PUSHF,
        ST_PUSHPC,
        ST_IPL,
        ST_JUMP
    } seq_state_t;

    typedef struct packed {
        logic             hw;
        logic             keep_ssel;
        logic [VEC_W-1:0] vec;
        logic [LVL_W-1:0] lvl;
    } entry_info_t;

    function automatic logic [FLG_W-1:0] entry_flags(input logic [FLG_W-1:0] snap,
                                                     input logic keep_ssel);
        logic [FLG_W-1:0] f;
        f = snap;
        f[FLG_IEN] = 1'b0;
        f[FLG_DBG] = 1'b0;
        if (!keep_ssel)
            f[FLG_SSEL] = 1'b0;
        return f;
    endfunction

endpackage

// File: rtl/irq_accept.sv
module irq_accept
    import irq_entry_pkg::*;
(
    input  logic             active,
    input  logic             instr_done,
    input  logic             instr_susp,
    input  logic             req_pending,
    input  logic [LVL_W-1:0] req_level,
    input  logic [LVL_W-1:0] ipl_cur,
    input  logic             swi_req,
    input  logic             ien,
    output logic             accept,
    output logic             take_sw,
    output logic             abort
);
    logic sw_ok;
    logic hw_ok;
    logic boundary;

    always_comb begin
        boundary = instr_done | instr_susp;
        sw_ok    = swi_req & instr_done;
        hw_ok    = req_pending & ien & (req_level > ipl_cur) & boundary;
        accept   = !active & (sw_ok | hw_ok);
        take_sw  = sw_ok;
        abort    = !active & !sw_ok & hw_ok & instr_susp & !instr_done;
    end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_entry_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             is_hw,
    output seq_state_t       state_o,
    output logic             busy,
    output logic             info_rd,
    output logic             req_clr,
    output logic             flags_we,
    output logic             push_flags,
    output logic             push_pc,
    output logic             ipl_we,
    output logic             redirect,
    output logic [LAT_W-1:0] lat_count
);
    seq_state_t       state, nxt;
    logic [LAT_W-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = accept ? ST_INFO : ST_IDLE;
            ST_INFO:   nxt = ST_CLRQ;
            ST_CLRQ:   nxt = ST_FLAG;
            ST_FLAG:   nxt = ST_PUSHF;
            ST_PUSHF:  nxt = ST_PUSHPC;
            ST_PUSHPC: nxt = ST_IPL;
            ST_IPL:    nxt = ST_JUMP;
            ST_JUMP:   nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE && accept)
                cnt <= LAT_W'(1);
            else if (state != ST_IDLE && state != ST_JUMP)
                cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        state_o    = state;
        busy       = accept | (state != ST_IDLE);
        info_rd    = (state == ST_INFO) & is_hw;
        req_clr    = (state == ST_CLRQ) & is_hw;
        flags_we   = (state == ST_FLAG);
        push_flags = (state == ST_PUSHF);
        push_pc    = (state == ST_PUSHPC);
        ipl_we     = (state == ST_IPL) & is_hw;
        redirect   = (state == ST_JUMP);
        lat_count  = cnt;
    end

    assert_one_step_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({info_rd, req_clr, flags_we, push_flags, push_pc, ipl_we, redirect}));

    assert_clear_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        req_clr |-> $past(info_rd));

    assert_busy_held_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && !redirect) |=> busy);

    assert_flags_then_push_R7: assert property (@(posedge clk) disable iff (rst)
        flags_we |=> push_flags);

    assert_latency_R12: assert property (@(posedge clk) disable iff (rst)
        redirect |-> (lat_count == LAT_W'(ENTRY_LAT)));
endmodule

// File: rtl/irq_stack_path.sv
module irq_stack_path
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int PUSH_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              new_sel,
    input  logic [ADDR_W-1:0] isp_in,
    input  logic [ADDR_W-1:0] usp_in,
    input  logic              push_flags,
    input  logic              push_pc,
    input  logic [DATA_W-1:0] flag_word,
    input  logic [DATA_W-1:0] pc_word,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              sp_we,
    output logic              sp_sel,
    output logic [ADDR_W-1:0] sp_new
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PUSH_BYTES);

    logic [ADDR_W-1:0] sp_work;
    logic              sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_work <= '0;
            sel_q   <= 1'b0;
        end else if (load) begin
            sp_work <= (new_sel ? usp_in : isp_in) - STEP;
            sel_q   <= new_sel;
        end else if (push_flags) begin
            sp_work <= sp_work - STEP;
        end
    end

    always_comb begin
        stk_we    = push_flags | push_pc;
        stk_addr  = sp_work;
        stk_wdata = push_pc ? pc_word : flag_word;
        sp_we     = push_pc;
        sp_sel    = sel_q;
        sp_new    = sp_work;
    end

    assert_push_descends_R8: assert property (@(posedge clk) disable iff (rst)
        (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - STEP));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = FLG_W,
    parameter int VEC_BASE   = 16'hFF00,
    parameter int VEC_STRIDE = 4,
    parameter int PUSH_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_done,
    input  logic              instr_susp,
    input  logic              req_pending,
    input  logic [LVL_W-1:0]  req_level,
    input  logic              swi_req,
    input  logic [VEC_W-1:0]  swi_num,
    input  logic [FLG_W-1:0]  flags_in,
    input  logic [DATA_W-1:0] pc_in,
    input  logic [LVL_W-1:0]  ipl_cur,
    input  logic [ADDR_W-1:0] isp_in,
    input  logic [ADDR_W-1:0] usp_in,
    input  logic [VEC_W-1:0]  info_vec,
    input  logic [LVL_W-1:0]  info_lvl,
    output logic              busy,
    output logic              instr_abort,
    output logic              info_rd,
    output logic [ADDR_W-1:0] info_addr,
    output logic              req_clr,
    output logic              flags_we,
    output logic [FLG_W-1:0]  flags_out,
    output logic              stk_we,
    output logic [ADDR_W-1:0] stk_addr,
    output logic [DATA_W-1:0] stk_wdata,
    output logic              sp_we,
    output logic              sp_sel,
    output logic [ADDR_W-1:0] sp_new,
    output logic              ipl_we,
    output logic [LVL_W-1:0]  ipl_out,
    output logic              redirect,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [LAT_W-1:0]  lat_count
);
    seq_state_t       state;
    logic             accept, take_sw;
    logic             push_flags, push_pc;
    entry_info_t      ent;
    logic [FLG_W-1:0] snap_q;
    logic [DATA_W-1:0] pc_q;
    logic [FLG_W-1:0] new_flags;

    irq_accept u_accept (
        .active      (state != ST_IDLE),
        .instr_done  (instr_done),
        .instr_susp  (instr_susp),
        .req_pending (req_pending),
        .req_level   (req_level),
        .ipl_cur     (ipl_cur),
        .swi_req     (swi_req),
        .ien         (flags_in[FLG_IEN]),
        .accept      (accept),
        .take_sw     (take_sw),
        .abort       (instr_abort)
    );

    irq_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .is_hw      (ent.hw),
        .state_o    (state),
        .busy       (busy),
        .info_rd    (info_rd),
        .req_clr    (req_clr),
        .flags_we   (flags_we),
        .push_flags (push_flags),
        .push_pc    (push_pc),
        .ipl_we     (ipl_we),
        .redirect   (redirect),
        .lat_count  (lat_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ent    <= '0;
            snap_q <= '0;
            pc_q   <= '0;
        end else if (state == ST_IDLE && accept) begin
            snap_q        <= flags_in;
            pc_q          <= pc_in;
            ent.hw        <= !take_sw;
            ent.keep_ssel <= take_sw && (int'(swi_num) >= SWI_KEEP_MIN);
            ent.vec       <= swi_num;
            ent.lvl       <= '0;
        end else if (state == ST_INFO && ent.hw) begin
            ent.vec <= info_vec;
            ent.lvl <= info_lvl;
        end
    end

    always_comb begin
        new_flags     = entry_flags(snap_q, ent.keep_ssel);
        flags_out     = new_flags;
        info_addr     = '0;
        ipl_out       = ent.lvl;
        redirect_addr = ADDR_W'(VEC_BASE) + ADDR_W'(ent.vec) * ADDR_W'(VEC_STRIDE);
    end

    irq_stack_path #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .PUSH_BYTES (PUSH_BYTES)
    ) u_stack (
        .clk        (clk),
        .rst        (rst),
        .load       (flags_we),
        .new_sel    (new_flags[FLG_SSEL]),
        .isp_in     (isp_in),
        .usp_in     (usp_in),
        .push_flags (push_flags),
        .push_pc    (push_pc),
        .flag_word  (DATA_W'(snap_q)),
        .pc_word    (pc_q),
        .stk_we     (stk_we),
        .stk_addr   (stk_addr),
        .stk_wdata  (stk_wdata),
        .sp_we      (sp_we),
        .sp_sel     (sp_sel),
        .sp_new     (sp_new)
    );

    assert_abort_needs_accept_R3: assert property (@(posedge clk) disable iff (rst)
        instr_abort |-> (busy && !instr_done));

    assert_flags_cleared_R6: assert property (@(posedge clk) disable iff (rst)
        flags_we |-> (!flags_out[FLG_IEN] && !flags_out[FLG_DBG]));

    assert_ipl_only_hw_R9: assert property (@(posedge clk) disable iff (rst)
        ipl_we |-> $past(req_clr, 4));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        instr_done, instr_susp, req_pending, swi_req;
    logic [2:0]  req_level, ipl_cur, info_lvl;
    logic [5:0]  swi_num, info_vec;
    logic [15:0] flags_in, pc_in, isp_in, usp_in;
    logic        busy, instr_abort, info_rd, req_clr, flags_we, stk_we, sp_we, sp_sel;
    logic        ipl_we, redirect;
    logic [15:0] info_addr, flags_out, stk_addr, stk_wdata, sp_new, redirect_addr;
    logic [2:0]  ipl_out;
    logic [3:0]  lat_count;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst(rst), .instr_done(instr_done), .instr_susp(instr_susp),
        .req_pending(req_pending), .req_level(req_level), .swi_req(swi_req),
        .swi_num(swi_num), .flags_in(flags_in), .pc_in(pc_in), .ipl_cur(ipl_cur),
        .isp_in(isp_in), .usp_in(usp_in), .info_vec(info_vec), .info_lvl(info_lvl),
        .busy(busy), .instr_abort(instr_abort), .info_rd(info_rd), .info_addr(info_addr),
        .req_clr(req_clr), .flags_we(flags_we), .flags_out(flags_out), .stk_we(stk_we),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .sp_we(sp_we), .sp_sel(sp_sel),
        .sp_new(sp_new), .ipl_we(ipl_we), .ipl_out(ipl_out), .redirect(redirect),
        .redirect_addr(redirect_addr), .lat_count(lat_count)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_flags(input logic [15:0] f, input logic keep);
        logic [15:0] r;
        r = f & ~16'h0060;
        if (!keep) r[7] = 1'b0;
        return r;
    endfunction

    function automatic logic exp_accept_hw(input logic pend, input logic [15:0] f,
                                           input logic [2:0] lv, input logic [2:0] ip,
                                           input logic done, input logic susp);
        return pend && f[6] && (lv > ip) && (done || susp);
    endfunction

    task automatic quiet();
        instr_done = 0; instr_susp = 0; req_pending = 0; swi_req = 0;
        req_level = 0; swi_num = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic trial(input logic sw, input logic done, input logic susp, input logic pend,
                         input logic [2:0] lv, input logic [2:0] ip,
                         input logic [15:0] flg, input logic [5:0] sn);
        logic e_sw, e_hw, e_acc, e_abort, hw, keep;
        logic [15:0] pc, nf, base, isp, usp;
        logic [5:0]  iv, vec;
        logic [2:0]  il;
        e_sw    = sw && done;
        e_hw    = exp_accept_hw(pend, flg, lv, ip, done, susp);
        e_acc   = e_sw || e_hw;
        e_abort = !e_sw && e_hw && susp && !done;
        pc  = 16'($urandom);
        isp = 16'($urandom) | 16'h0100;
        usp = 16'($urandom) | 16'h0100;
        iv  = 6'($urandom);
        il  = 3'($urandom);
        instr_done = done; instr_susp = susp; req_pending = pend; swi_req = sw;
        req_level = lv; ipl_cur = ip; flags_in = flg; swi_num = sn; pc_in = pc;
        isp_in = isp; usp_in = usp; info_vec = iv; info_lvl = il;
        #1;
        chk("R2", "busy at acceptance", busy, e_acc);
        chk("R3", "instr_abort", instr_abort, e_abort);
        step();
        if (!e_acc) begin
            quiet();
            #1;
            chk("R2", "no start info_rd", info_rd, 0);
            chk("R2", "no start busy", busy, 0);
            return;
        end
        hw   = !e_sw;
        keep = e_sw && (sn >= 6'd32);
        nf   = exp_flags(flg, keep);
        base = nf[7] ? usp : isp;
        vec  = hw ? iv : sn;
        // provoke a second acceptance during the sequence; scramble captured inputs
        instr_done = 1; req_pending = 1; req_level = 3'd7; ipl_cur = 0; swi_req = 1;
        flags_in = 16'($urandom) | 16'h0040; pc_in = 16'($urandom); swi_num = 6'($urandom);
        #1;
        chk("R4", "info_rd", info_rd, hw);
        chk("R4", "info_addr", info_addr, 0);
        chk("R11", "busy A+1", busy, 1);
        step();
        info_vec = 6'($urandom); info_lvl = 3'($urandom);
        #1;
        chk("R5", "req_clr", req_clr, hw);
        step();
        chk("R6", "flags_we", flags_we, 1);
        chk("R6", "flags_out", flags_out, nf);
        step();
        chk("R7", "stk_we flags", stk_we, 1);
        chk("R7", "stk_addr flags", stk_addr, 16'(base - 16'd2));
        chk("R7", "stk_wdata flags", stk_wdata, flg);
        step();
        chk("R8", "stk_wdata pc", stk_wdata, pc);
        chk("R8", "stk_addr pc", stk_addr, 16'(base - 16'd4));
        chk("R8", "sp_we", sp_we, 1);
        chk("R8", "sp_new", sp_new, 16'(base - 16'd4));
        chk("R8", "sp_sel", sp_sel, nf[7]);
        step();
        chk("R9", "ipl_we", ipl_we, hw);
        if (hw) chk("R9", "ipl_out", ipl_out, il);
        step();
        chk("R10", "redirect", redirect, 1);
        chk("R10", "redirect_addr", redirect_addr, 16'(16'hFF00 + 16'(vec) * 16'd4));
        chk("R12", "lat_count at redirect", lat_count, 7);
        chk("R11", "busy A+7", busy, 1);
        quiet();
        step();
        chk("R11", "idle A+8 busy", busy, 0);
        chk("R11", "idle A+8 redirect", redirect, 0);
        chk("R12", "lat_count held", lat_count, 7);
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        quiet();
        rst = 1; flags_in = 0; pc_in = 0; ipl_cur = 0; isp_in = 16'h0400; usp_in = 16'h0800;
        info_vec = 0; info_lvl = 0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "strobes", {instr_abort, info_rd, req_clr, flags_we, stk_we, sp_we, ipl_we, redirect}, 0);
        chk("R1", "lat_count", lat_count, 0);
        @(negedge clk);
        // R2 level above ipl with enable
        trial(0, 1, 0, 1, 3'd5, 3'd2, 16'h00C0, 6'd0);
        // R2 level equal to ipl: rejected
        trial(0, 1, 0, 1, 3'd3, 3'd3, 16'h0040, 6'd0);
        // R2 enable clear: rejected
        trial(0, 1, 0, 1, 3'd7, 3'd0, 16'h00A0, 6'd0);
        // R3 suspendable instruction aborted
        trial(0, 0, 1, 1, 3'd6, 3'd1, 16'h0040, 6'd0);
        // R3 no boundary: rejected
        trial(0, 0, 0, 1, 3'd6, 3'd1, 16'h0040, 6'd0);
        // R6 software entry numbered 40 keeps select flag
        trial(1, 1, 0, 0, 3'd0, 3'd0, 16'h00E0, 6'd40);
        // R6 software entry numbered 10 clears select flag
        trial(1, 1, 0, 0, 3'd0, 3'd0, 16'h00E0, 6'd10);
        // R2 software entry with enable clear, and boundary at 31/32
        trial(1, 1, 0, 0, 3'd0, 3'd7, 16'h0080, 6'd31);
        trial(1, 1, 0, 0, 3'd0, 3'd7, 16'h0080, 6'd32);
        // R2 software wins over hardware; R9 no ipl write
        trial(1, 1, 0, 1, 3'd7, 3'd0, 16'h00C0, 6'd63);
        for (int i = 0; i < 300; i++) begin
            trial(($urandom % 4) == 0, ($urandom % 2) == 1, ($urandom % 3) == 0,
                  ($urandom % 4) != 0, 3'($urandom), 3'($urandom),
                  16'($urandom), 6'($urandom));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule